// File: doc/BRIEF.md
# Bus-Mastering Block Transfer Channel

This block is one transfer channel that copies a run of words between system memory and a single peripheral. The processor does not take part in the copy. Software loads a word address, a word count and a control word through a small register port. Once started, the channel wins the shared system bus through a three-wire mastership handshake: request, grant and a shared busy line. It then performs one memory access per word. The peripheral offers or accepts each word with a ready/acknowledge pair.

Two bus-holding policies are available. In cycle-stealing mode the channel gives the bus back after every word and asks for it again. In burst mode it keeps the bus until the whole block has moved. When the count runs out, the channel flags completion and can raise an interrupt line, which software clears by reading the control word.

Top module: `dma_chan`

## Requirements
- R1: After synchronous reset, `bus_req`, `bus_busy_out`, `irq` and `mem_en` are low, and reads of all three registers return 0.
- R2: `reg_sel` picks the register: 0 is control, 1 is word address, 2 is word count. In the control word, bit 31 is the interrupt flag, bit 30 is the done flag, bit 2 selects burst mode, bit 1 enables the interrupt, and bit 0 is the direction (1 = peripheral to memory, 0 = memory to peripheral). All other bits read as 0.
- R3: A control write while the channel is idle loads bits 2..0. If the count is nonzero, the write also starts a transfer and clears the done and interrupt flags. While a transfer is in progress, writes to any register are ignored.
- R4: To gain the bus, the channel raises `bus_req`. The cycle after it sees `bus_grant`, it drops `bus_req`. It then waits until `bus_busy_in` is low, and only after that raises `bus_busy_out`. `bus_req` and `bus_busy_out` are never high together.
- R5: While holding the bus, the channel makes exactly one memory access (`mem_en`, which is also `dev_ack`) in each cycle where `dev_rdy` is high. After each access the address grows by DATA_W/8 and the count falls by one.
- R6: In cycle-stealing mode, `bus_busy_out` drops in the cycle after each word, and the channel requests the bus again for the next word.
- R7: In burst mode, `bus_busy_out` stays high from the first word to the last, including cycles where the peripheral stalls.
- R8: When the last word moves, the channel sets done, releases the bus, and sets the interrupt flag only when interrupt enable is 1.
- R9: A read of the control register returns the current flags and then clears the interrupt flag and the `irq` output.
- R10: A start with count 0 sets done at once, and sets the interrupt flag if it is enabled. `bus_req` is never raised.
- R11: With direction 1, the peripheral's data is written to memory at the current address (`mem_we` high). With direction 0, the memory word at the current address is delivered on `dev_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (control read clears the interrupt) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| bus_busy_in | input | 1 | Bus held by another master |
| bus_busy_out | output | 1 | Bus held by this channel |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Data written to memory |
| mem_rdata | input | DATA_W | Data read from memory, same cycle |
| dev_rdy | input | 1 | Peripheral has a word or can take one |
| dev_ack | output | 1 | Word taken from or given to peripheral |
| dev_din | input | DATA_W | Word from peripheral |
| dev_dout | output | DATA_W | Word to peripheral |

## Verification
The embedded properties check the following on every cycle:
- the mastership handshake: request dropped after a grant, busy taken only over a free line, request and busy never high together;
- the release after each word in cycle-stealing mode and the unbroken hold in burst mode;
- the address and count step per access;
- the interrupt being gated by its enable, and a control read clearing the interrupt.

Only the bench's scenarios can show that whole blocks land at the right memory locations in order, in both directions. The same holds for writes during a transfer being ignored, for a zero-count start never touching the bus, and for the exact values software reads back after each run.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_REQ  = 2'd1,
        CH_WAIT = 2'd2,
        CH_OWN  = 2'd3
    } ch_state_e;

    localparam logic [1:0] SEL_CTL  = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;

    localparam int B_IRQ   = 31;
    localparam int B_DONE  = 30;
    localparam int B_BURST = 2;
    localparam int B_IE    = 1;
    localparam int B_DIR   = 0;

    typedef struct packed {
        logic irq;
        logic done;
        logic burst;
        logic ie;
        logic dir;
    } ctl_t;

    function automatic logic [31:0] pack_ctl(input ctl_t c);
        logic [31:0] r;
        r          = '0;
        r[B_IRQ]   = c.irq;
        r[B_DONE]  = c.done;
        r[B_BURST] = c.burst;
        r[B_IE]    = c.ie;
        r[B_DIR]   = c.dir;
        return r;
    endfunction

endpackage

// File: rtl/dma_regs.sv
`timescale 1ns/1ps
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              idle,
    input  logic              beat,
    output logic              start,
    output logic              last,
    output ctl_t              ctl,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  count
);
    logic ctl_wr, zero_go, finish, wdata_unused;

    assign ctl_wr       = wr && (sel == SEL_CTL) && idle;
    assign start        = ctl_wr && (count != '0);
    assign zero_go      = ctl_wr && (count == '0);
    assign last         = (count == CNT_W'(1));
    assign finish       = beat && last;
    assign wdata_unused = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (ctl_wr) begin
            ctl.ie    <= wdata[B_IE];
            ctl.dir   <= wdata[B_DIR];
            ctl.burst <= wdata[B_BURST];
            ctl.done  <= zero_go;
            ctl.irq   <= zero_go && wdata[B_IE];
        end else if (finish) begin
            ctl.done <= 1'b1;
            if (ctl.ie) ctl.irq <= 1'b1;
        end else if (rd && (sel == SEL_CTL)) begin
            ctl.irq <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            count <= '0;
        end else begin
            if (wr && idle && (sel == SEL_ADDR)) addr <= wdata[ADDR_W-1:0];
            else if (beat)                       addr <= addr + ADDR_W'(STEP);
            if (wr && idle && (sel == SEL_CNT))  count <= wdata[CNT_W-1:0];
            else if (beat)                       count <= count - CNT_W'(1);
        end
    end

    always_comb begin
        case (sel)
            SEL_CTL:  rdata = pack_ctl(ctl);
            SEL_ADDR: rdata = 32'(addr);
            SEL_CNT:  rdata = 32'(count);
            default:  rdata = '0;
        endcase
    end

    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        beat |=> (addr == $past(addr) + ADDR_W'(STEP)));
    a_r5_count_dec: assert property (@(posedge clk) disable iff (rst)
        beat |=> (count == $past(count) - CNT_W'(1)));
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.irq) |-> ctl.ie);
    a_r8_done_set: assert property (@(posedge clk) disable iff (rst)
        finish |=> ctl.done);
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd && (sel == SEL_CTL) && !finish && !ctl_wr) |=> !ctl.irq);
    a_r10_zero_done: assert property (@(posedge clk) disable iff (rst)
        zero_go |=> ctl.done);
endmodule

// File: rtl/dma_bus_fsm.sv
`timescale 1ns/1ps
module dma_bus_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic burst,
    input  logic last,
    input  logic dev_rdy,
    input  logic grant,
    input  logic busy_in,
    output logic req,
    output logic own,
    output logic beat,
    output logic idle
);
    ch_state_e state, state_nx;

    assign req  = (state == CH_REQ);
    assign own  = (state == CH_OWN);
    assign idle = (state == CH_IDLE);
    assign beat = own && dev_rdy;

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (start)    state_nx = CH_REQ;
            CH_REQ:  if (grant)    state_nx = CH_WAIT;
            CH_WAIT: if (!busy_in) state_nx = CH_OWN;
            CH_OWN:  if (beat) begin
                if (last)        state_nx = CH_IDLE;
                else if (!burst) state_nx = CH_REQ;
            end
            default: state_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CH_IDLE;
        else     state <= state_nx;
    end

    a_r4_req_drop: assert property (@(posedge clk) disable iff (rst)
        (req && grant) |=> !req);
    a_r4_take_free: assert property (@(posedge clk) disable iff (rst)
        $rose(own) |-> !$past(busy_in));
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(req && own));
    a_r6_steal_release: assert property (@(posedge clk) disable iff (rst)
        (beat && !burst) |=> !own);
    a_r7_burst_hold: assert property (@(posedge clk) disable iff (rst)
        (own && burst && !(beat && last)) |=> own);
    a_r8_release_end: assert property (@(posedge clk) disable iff (rst)
        (beat && last) |=> (!own && !req));
endmodule

// File: rtl/dma_chan.sv
`timescale 1ns/1ps
module dma_chan
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_grant,
    input  logic              bus_busy_in,
    output logic              bus_busy_out,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_rdy,
    output logic              dev_ack,
    input  logic [DATA_W-1:0] dev_din,
    output logic [DATA_W-1:0] dev_dout
);
    localparam int STEP = DATA_W / 8;

    ctl_t              ctl;
    logic              start, last, beat, idle;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  count;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_regs (
        .clk(clk), .rst(rst), .sel(reg_sel), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .rdata(reg_rdata), .idle(idle), .beat(beat),
        .start(start), .last(last), .ctl(ctl), .addr(addr), .count(count)
    );

    dma_bus_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .burst(ctl.burst), .last(last),
        .dev_rdy(dev_rdy), .grant(bus_grant), .busy_in(bus_busy_in),
        .req(bus_req), .own(bus_busy_out), .beat(beat), .idle(idle)
    );

    assign irq       = ctl.irq;
    assign mem_en    = beat;
    assign mem_we    = ctl.dir;
    assign mem_addr  = addr;
    assign mem_wdata = dev_din;
    assign dev_ack   = beat;
    assign dev_dout  = mem_rdata;

    a_r11_access_owned: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (bus_busy_out && dev_rdy));
endmodule

// File: tb/sim_dma_chan.sv
`timescale 1ns/1ps
module sim_dma_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, bus_req, bus_busy_out, mem_en, mem_we, dev_ack;
    logic        bus_grant = 1'b0, bus_busy_in = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dev_dout, dev_din;
    logic        dev_rdy;

    int errors = 0, checks = 0;
    bit hold_grant = 0, stall_mode = 0;
    int tick = 0;
    logic [31:0] src_cnt = '0;
    logic [31:0] mem [0:255];
    logic [31:0] sinkq [$];

    // reference model state
    int          m_st = 0;
    logic [31:0] m_addr = '0;
    int          m_cnt = 0;
    bit          m_ie, m_dir, m_burst, m_done, m_irq;
    bit          m_beat;

    always #4 clk = ~clk;

    assign dev_rdy   = stall_mode ? (tick % 3 != 0) : 1'b1;
    assign dev_din   = 32'hA000_0000 + src_cnt;
    assign mem_rdata = mem[mem_addr[9:2]];

    dma_chan u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .bus_req(bus_req),
        .bus_grant(bus_grant), .bus_busy_in(bus_busy_in), .bus_busy_out(bus_busy_out),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dev_rdy(dev_rdy), .dev_ack(dev_ack), .dev_din(dev_din),
        .dev_dout(dev_dout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // environment: arbiter, memory, peripheral source and sink
    always @(posedge clk) begin
        tick      <= tick + 1;
        bus_grant <= rst ? 1'b0 : (bus_req && !hold_grant);
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'h1000 + i;
            src_cnt <= '0;
        end else begin
            if (mem_en && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            if (dev_ack && mem_we) src_cnt <= src_cnt + 1;
            if (dev_ack && !mem_we) sinkq.push_back(dev_dout);
        end
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_addr = '0; m_cnt = 0;
            {m_ie, m_dir, m_burst, m_done, m_irq} = '0;
        end else begin
            m_beat = (m_st == 3) && dev_rdy;
            if (reg_wr && m_st == 0 && reg_sel == 2'd0) begin
                m_ie = reg_wdata[1]; m_dir = reg_wdata[0]; m_burst = reg_wdata[2];
                m_done = (m_cnt == 0);
                m_irq  = (m_cnt == 0) && reg_wdata[1];
                if (m_cnt != 0) m_st = 1;
            end else begin
                if (m_beat && m_cnt == 1) begin
                    m_done = 1;
                    if (m_ie) m_irq = 1;
                end else if (reg_rd && reg_sel == 2'd0) m_irq = 0;
                case (m_st)
                    1: if (bus_grant) m_st = 2;
                    2: if (!bus_busy_in) m_st = 3;
                    3: if (m_beat) m_st = (m_cnt == 1) ? 0 : (m_burst ? 3 : 1);
                    default: ;
                endcase
            end
            if (reg_wr && m_st == 0 && reg_sel == 2'd1) m_addr = reg_wdata;
            else if (m_beat) m_addr = m_addr + 4;
            if (reg_wr && m_st == 0 && reg_sel == 2'd2) m_cnt = int'(reg_wdata[15:0]);
            else if (m_beat) m_cnt = m_cnt - 1;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 bus_req", 32'(bus_req), 32'(m_st == 1));
            chk("R4/R6/R7 bus_busy_out", 32'(bus_busy_out), 32'(m_st == 3));
            chk("R8/R9 irq", 32'(irq), 32'(m_irq));
            chk("R5 mem_en", 32'(mem_en), 32'((m_st == 3) && dev_rdy));
            if (mem_en) begin
                chk("R5 mem_addr", mem_addr, m_addr);
                chk("R11 mem_we", 32'(mem_we), 32'(m_dir));
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(posedge clk); #1;
        reg_sel = s; reg_rd = 1'b1;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 bus_busy_out", 32'(bus_busy_out), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(2'd0, v); chk("R1 ctl", v, 0);
        rd(2'd1, v); chk("R1 addr", v, 0);
        rd(2'd2, v); chk("R1 count", v, 0);

        // memory to peripheral, cycle stealing, interrupt on
        wr(2'd2, 4); wr(2'd1, 32'h40); wr(2'd0, 32'h2);
        repeat (50) @(posedge clk);
        chk("R11 sink size", sinkq.size(), 4);
        for (int k = 0; k < 4 && k < sinkq.size(); k++)
            chk("R11 sink word", sinkq[k], 32'h1010 + k);
        chk("R8 irq raised", 32'(irq), 1);
        rd(2'd0, v); chk("R2/R8 ctl after block", v, 32'hC000_0002);
        @(negedge clk); chk("R9 irq cleared", 32'(irq), 0);
        rd(2'd0, v); chk("R9 ctl reread", v, 32'h4000_0002);
        rd(2'd1, v); chk("R5 addr end", v, 32'h50);
        rd(2'd2, v); chk("R5 count end", v, 0);

        // peripheral to memory, burst, stalls, busy bus first
        wr(2'd2, 5); wr(2'd1, 32'h100);
        bus_busy_in = 1'b1; stall_mode = 1;
        wr(2'd0, 32'h5);
        repeat (6) @(posedge clk);
        @(negedge clk); chk("R4 waits for free bus", 32'(bus_busy_out), 0);
        @(posedge clk); #1 bus_busy_in = 1'b0;
        repeat (40) @(posedge clk);
        stall_mode = 0;
        for (int k = 0; k < 5; k++)
            chk("R11 mem written", mem[64 + k], 32'hA000_0000 + k);
        chk("R11 next word untouched", mem[69], 32'h1045);
        chk("R8 no irq when disabled", 32'(irq), 0);
        rd(2'd0, v); chk("R7 ctl after burst", v, 32'h4000_0005);
        rd(2'd1, v); chk("R5 addr after burst", v, 32'h114);

        // zero count start
        wr(2'd2, 0); wr(2'd0, 32'h2);
        @(negedge clk); chk("R10 irq at once", 32'(irq), 1);
        rd(2'd0, v); chk("R10 ctl", v, 32'hC000_0002);

        // writes during a transfer are ignored
        sinkq.delete();
        wr(2'd2, 2); wr(2'd1, 32'h200);
        hold_grant = 1;
        wr(2'd0, 32'h0);
        repeat (3) @(posedge clk);
        wr(2'd1, 32'h300); wr(2'd2, 9); wr(2'd0, 32'h7);
        rd(2'd1, v); chk("R3 addr write ignored", v, 32'h200);
        rd(2'd2, v); chk("R3 count write ignored", v, 2);
        rd(2'd0, v); chk("R3 flags cleared on start", v, 0);
        @(posedge clk); #1 hold_grant = 0;
        repeat (30) @(posedge clk);
        rd(2'd1, v); chk("R5 addr final", v, 32'h208);
        rd(2'd2, v); chk("R5 count final", v, 0);
        rd(2'd0, v); chk("R8 done no irq", v, 32'h4000_0000);
        chk("R6 sink size", sinkq.size(), 2);
        for (int k = 0; k < 2 && k < sinkq.size(); k++)
            chk("R11 sink word b", sinkq[k], 32'h1080 + k);

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule